// File: doc/BRIEF.md
# E-paper panel row/frame sequencer

This block generates every control line that an active-matrix electrophoretic panel needs. It runs from the pixel clock. A single start strobe produces one complete frame. The frame begins with rows that load the gate shift register with its start token, followed by rows that clock the gate chain. After that come one data row per gate line and a flush row that keeps the last latched row driven. Two closing rows drop the gate mode line. Every pin level is decided by the row number and the clock position within the row. No hsync/vsync counter is involved.

Pixel data arrives as bytes over a ready/valid interface, with four 2-bit pixels per byte. The block asks for a byte only during the data clocks of the gate rows. A missing byte is sent to the panel as zero and sets a sticky underrun flag. All outputs come from flops. A one-clock done pulse marks the end of the frame, and on that same clock the pins return to their idle levels.

Top module: `epd_frame_seq`

## Requirements
- R1: When idle, including after reset, the outputs are as follows. Gate start and source start are high. Gate clock, gate mode, latch, output enable, done and the data bus are low, and ready is low.
- R2: A frame lasts (GATE_ROWS+9) rows of LEAD_CLKS+SRC_COLS/4+TRAIL_CLKS clocks each. Pin row r, column c appears r*row_len+c+1 clocks after the start edge. busy_o is high for exactly the frame length. done_o is high for one clock, on the clock after the last pin state, and the pins are idle on that clock.
- R3: Gate mode is high in every row except the last two. In those two rows gate mode, gate clock, latch and output enable are low, while gate start and source start are high.
- R4: Rows 0 to 2 are gate-start rows, with source start high and T = row_len/3. In row 0 the gate clock is high for columns 20 through 20+2T-1. In rows 1 and 2 it is high for columns below 2T. Gate start is low from row 1, column T, through row 2, column T-1, and high at all other times.
- R5: Rows 3 to 5 each have the gate clock high for columns below 2T, with gate start and source start high.
- R6: Data row j is panel row 6+j, for j from 0 to GATE_ROWS. In its lead section source start is high. Latch is high at columns 22 through 29, but only when j>0. Output enable is high at columns below 20 when j>=2, and at columns 28 onward when j>0. At every other lead column output enable is low.
- R7: In data rows the gate clock is high at the final 2 lead columns and at the first (SRC_COLS/4)/3 data columns. Gate start stays high throughout data rows.
- R8: In the data section of gate rows (j<GATE_ROWS), source start is low and output enable follows j>0. Source start is high in the trail. The data bus is zero whenever source start is high.
- R9: The flush row (j = GATE_ROWS) keeps source start high through the data section, requests no data and drives zero data.
- R10: Ready is high exactly during the data columns of rows with j<GATE_ROWS. An accepted byte appears on the data bus one clock later. A ready clock that has no valid byte puts zero on the bus and sets the underrun flag. The flag stays set until the next accepted start clears it.
- R11: A start strobe that arrives while a frame is running has no effect on the pin sequence or on the frame length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame launch strobe |
| pix_valid_i | input | 1 | Pixel byte valid |
| pix_data_i | input | 8 | Four 2-bit pixels |
| pix_ready_o | output | 1 | Pixel byte requested |
| src_data_o | output | 8 | Source driver data bus |
| src_start_o | output | 1 | Source start pulse |
| src_latch_o | output | 1 | Source latch enable |
| src_oe_o | output | 1 | Source output enable |
| gate_clk_o | output | 1 | Gate shift clock |
| gate_start_o | output | 1 | Gate start pulse |
| gate_mode_o | output | 1 | Gate mode |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-clock end-of-frame pulse |
| underrun_o | output | 1 | Sticky missing-pixel flag |

## Verification
A wrong row or column count shows on the pins within one clock. The cause can be a counter that wraps early, a region boundary that is off by one, or a latch or output-enable window that is shifted. The gate clock, latch or source start then takes a level that the bench's per-position model does not predict. A frame-length error appears on busy_o and done_o at the end of the frame. A data-path fault shows up one clock after the byte in question. Examples are a request in the flush row or a missed zero on underrun. The bench therefore compares every pin on every clock of three frames: one with valid data on every request, one with random gaps and a restart strobe in the middle of the frame, and one that checks the underrun flag is cleared.

// File: rtl/epd_seq_pkg.sv
package epd_seq_pkg;

  typedef struct packed {
    logic gmode;
    logic gsp;
    logic gclk;
    logic ssp;
    logic le;
    logic oe;
  } epd_pins_t;

  typedef enum logic [1:0] {
    RG_OPEN  = 2'd0,
    RG_EMPTY = 2'd1,
    RG_DATA  = 2'd2,
    RG_CLOSE = 2'd3
  } epd_region_t;

  localparam epd_pins_t PINS_IDLE = '{gmode: 1'b0, gsp: 1'b1, gclk: 1'b0,
                                      ssp: 1'b1, le: 1'b0, oe: 1'b0};

  localparam int N_OPEN  = 3;
  localparam int N_EMPTY = 3;
  localparam int N_CLOSE = 2;

endpackage

// File: rtl/epd_pos_counter.sv
module epd_pos_counter #(
  parameter int ROW_LEN = 304,
  parameter int N_ROWS  = 767,
  localparam int COL_W  = $clog2(ROW_LEN),
  localparam int ROW_W  = $clog2(N_ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             run_o,
  output logic             launch_o,
  output logic             last_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);

  logic col_end, row_end;

  assign col_end  = col_o == COL_W'(ROW_LEN - 1);
  assign row_end  = row_o == ROW_W'(N_ROWS - 1);
  assign last_o   = run_o & col_end & row_end;
  assign launch_o = start_i & ~run_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0;
      row_o <= '0;
      col_o <= '0;
    end else if (launch_o) begin
      run_o <= 1'b1;
      row_o <= '0;
      col_o <= '0;
    end else if (run_o) begin
      if (col_end) begin
        col_o <= '0;
        if (row_end) begin
          row_o <= '0;
          run_o <= 1'b0;
        end else begin
          row_o <= row_o + 1'b1;
        end
      end else begin
        col_o <= col_o + 1'b1;
      end
    end
  end

endmodule

// File: rtl/epd_row_decode.sv
module epd_row_decode
  import epd_seq_pkg::*;
#(
  parameter int LEAD_CLKS  = 40,
  parameter int DATA_CLKS  = 256,
  parameter int TRAIL_CLKS = 8,
  parameter int GATE_ROWS  = 758,
  parameter int SSP_HOLD   = 20,
  parameter int LE_GAP     = 2,
  parameter int LE_LEN     = 8,
  parameter int OE_DELAY   = 6,
  parameter int GCLK_LEAD  = 2,
  parameter int OPEN_IDLE  = 20,
  localparam int ROW_LEN   = LEAD_CLKS + DATA_CLKS + TRAIL_CLKS,
  localparam int N_ROWS    = N_OPEN + N_EMPTY + GATE_ROWS + 1 + N_CLOSE,
  localparam int COL_W     = $clog2(ROW_LEN),
  localparam int ROW_W     = $clog2(N_ROWS)
) (
  input  logic             run_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output epd_pins_t        pins_o,
  output logic             take_o
);

  localparam int THIRD    = ROW_LEN / 3;
  localparam int GCLK_DAT = DATA_CLKS / 3;
  localparam int LE_ON    = SSP_HOLD + LE_GAP;
  localparam int OE_ON    = LE_ON + OE_DELAY;
  localparam int DATA_END = LEAD_CLKS + DATA_CLKS;
  localparam int FIRST_DR = N_OPEN + N_EMPTY;

  epd_region_t region;
  int r, c, j;
  logic in_lead, in_data, in_trail, flush;

  always_comb begin
    r = int'(row_i);
    c = int'(col_i);
    j = r - FIRST_DR;
    if (r < N_OPEN)               region = RG_OPEN;
    else if (r < FIRST_DR)        region = RG_EMPTY;
    else if (j <= GATE_ROWS)      region = RG_DATA;
    else                          region = RG_CLOSE;
    in_lead  = c < LEAD_CLKS;
    in_data  = !in_lead && (c < DATA_END);
    in_trail = !in_lead && !in_data;
    flush    = j == GATE_ROWS;
  end

  always_comb begin
    pins_o = PINS_IDLE;
    take_o = 1'b0;
    if (run_i) begin
      pins_o.gmode = 1'b1;
      unique case (region)
        RG_OPEN: begin
          if (r == 0) begin
            pins_o.gclk = (c >= OPEN_IDLE) && (c < OPEN_IDLE + 2 * THIRD);
          end else begin
            pins_o.gclk = c < 2 * THIRD;
            // token low across the row 1/2 boundary
            pins_o.gsp  = (r == 1) ? (c < THIRD) : (c >= THIRD);
          end
        end
        RG_EMPTY: pins_o.gclk = c < 2 * THIRD;
        RG_DATA: begin
          pins_o.ssp  = in_lead || in_trail || flush;
          pins_o.le   = (j != 0) && in_lead && (c >= LE_ON) && (c < LE_ON + LE_LEN);
          if (in_lead)
            pins_o.oe = (c < SSP_HOLD) ? (j >= 2) : ((j != 0) && (c >= OE_ON));
          else
            pins_o.oe = j != 0;
          pins_o.gclk = (in_lead && (c >= LEAD_CLKS - GCLK_LEAD)) ||
                        (in_data && (c < LEAD_CLKS + GCLK_DAT));
          take_o      = in_data && !flush;
        end
        default: pins_o.gmode = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/epd_pix_path.sv
module epd_pix_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              launch_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              underrun_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o     <= '0;
      underrun_o <= 1'b0;
    end else begin
      data_o <= (take_i && valid_i) ? data_i : '0;
      if (launch_i)                 underrun_o <= 1'b0;
      else if (take_i && !valid_i)  underrun_o <= 1'b1;
    end
  end

endmodule

// File: rtl/epd_frame_seq.sv
module epd_frame_seq
  import epd_seq_pkg::*;
#(
  parameter int SRC_COLS   = 1024,
  parameter int DATA_W     = 8,
  parameter int LEAD_CLKS  = 40,
  parameter int TRAIL_CLKS = 8,
  parameter int GATE_ROWS  = 758,
  localparam int PIX_PER_CLK = DATA_W / 2,
  localparam int DATA_CLKS   = SRC_COLS / PIX_PER_CLK,
  localparam int ROW_LEN     = LEAD_CLKS + DATA_CLKS + TRAIL_CLKS,
  localparam int N_ROWS      = N_OPEN + N_EMPTY + GATE_ROWS + 1 + N_CLOSE,
  localparam int COL_W       = $clog2(ROW_LEN),
  localparam int ROW_W       = $clog2(N_ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pix_valid_i,
  input  logic [DATA_W-1:0] pix_data_i,
  output logic              pix_ready_o,
  output logic [DATA_W-1:0] src_data_o,
  output logic              src_start_o,
  output logic              src_latch_o,
  output logic              src_oe_o,
  output logic              gate_clk_o,
  output logic              gate_start_o,
  output logic              gate_mode_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              underrun_o
);

  logic             run, launch, last, take, fin_q;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  epd_pins_t        pins_d, pins_q;

  epd_pos_counter #(
    .ROW_LEN (ROW_LEN),
    .N_ROWS  (N_ROWS)
  ) i_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .run_o    (run),
    .launch_o (launch),
    .last_o   (last),
    .row_o    (row),
    .col_o    (col)
  );

  epd_row_decode #(
    .LEAD_CLKS  (LEAD_CLKS),
    .DATA_CLKS  (DATA_CLKS),
    .TRAIL_CLKS (TRAIL_CLKS),
    .GATE_ROWS  (GATE_ROWS)
  ) i_dec (
    .run_i  (run),
    .row_i  (row),
    .col_i  (col),
    .pins_o (pins_d),
    .take_o (take)
  );

  epd_pix_path #(
    .DATA_W (DATA_W)
  ) i_pix (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .launch_i   (launch),
    .valid_i    (pix_valid_i),
    .data_i     (pix_data_i),
    .data_o     (src_data_o),
    .underrun_o (underrun_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_q <= PINS_IDLE;
      fin_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      pins_q <= pins_d;
      fin_q  <= last;
      done_o <= fin_q;
    end
  end

  assign pix_ready_o  = take;
  assign busy_o       = run;
  assign gate_mode_o  = pins_q.gmode;
  assign gate_start_o = pins_q.gsp;
  assign gate_clk_o   = pins_q.gclk;
  assign src_start_o  = pins_q.ssp;
  assign src_latch_o  = pins_q.le;
  assign src_oe_o     = pins_q.oe;

endmodule

// File: rtl/epd_frame_seq_chk.sv
module epd_frame_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              pix_valid_i,
  input logic              pix_ready_o,
  input logic [DATA_W-1:0] src_data_o,
  input logic              src_start_o,
  input logic              src_latch_o,
  input logic              src_oe_o,
  input logic              gate_clk_o,
  input logic              gate_start_o,
  input logic              gate_mode_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              underrun_o
);

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2

  AST_IDLE_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (gate_start_o && src_start_o && !gate_clk_o && !gate_mode_o &&
                !src_latch_o && !src_oe_o && src_data_o == '0)); // R1

  AST_MODE_LOW_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_mode_o |-> (!src_latch_o && !src_oe_o && !gate_clk_o)); // R3

  AST_LATCH_IN_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_latch_o |-> (gate_mode_o && src_start_o && gate_start_o)); // R6

  AST_SSP_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_start_o |-> src_data_o == '0); // R8

  AST_READY_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ready_o |-> busy_o); // R10

  AST_UNDERRUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && underrun_o) |=> underrun_o); // R10

  AST_MISS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_ready_o && !pix_valid_i) |=> (underrun_o && src_data_o == '0)); // R10

endmodule

bind epd_frame_seq epd_frame_seq_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_epd_frame_seq.sv
module test_epd_frame_seq;

  localparam int LEAD  = 40;
  localparam int DCLK  = 24;
  localparam int TRAIL = 8;
  localparam int GATES = 4;
  localparam int RL    = LEAD + DCLK + TRAIL;
  localparam int NR    = GATES + 9;
  localparam int FRAME = RL * NR;
  localparam int T3    = RL / 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       pix_valid_i = 1'b0;
  logic [7:0] pix_data_i = '0;
  logic       pix_ready_o, src_start_o, src_latch_o, src_oe_o;
  logic       gate_clk_o, gate_start_o, gate_mode_o, busy_o, done_o, underrun_o;
  logic [7:0] src_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  epd_frame_seq #(
    .SRC_COLS   (DCLK * 4),
    .DATA_W     (8),
    .LEAD_CLKS  (LEAD),
    .TRAIL_CLKS (TRAIL),
    .GATE_ROWS  (GATES)
  ) i_epd_frame_seq (.*);

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // {gmode, gsp, gclk, ssp, le, oe}
  function automatic logic [5:0] exp_pins(int p);
    int r = p / RL;
    int c = p % RL;
    int j = r - 6;
    logic gm = 1, gs = 1, gc = 0, ss = 1, le = 0, oe = 0;
    if (r == 0) gc = (c >= 20 && c < 20 + 2 * T3);
    else if (r < 6) gc = (c < 2 * T3);
    if (r == 1 && c >= T3) gs = 0;
    if (r == 2 && c < T3) gs = 0;
    if (j >= 0 && j <= GATES) begin
      if (c < LEAD) begin
        le = (j > 0) && c >= 22 && c <= 29;
        oe = (c < 20) ? (j >= 2) : ((j > 0) && c >= 28);
        gc = c >= LEAD - 2;
      end else begin
        oe = j > 0;
        gc = (c < LEAD + DCLK) && (c - LEAD < DCLK / 3);
        ss = (c >= LEAD + DCLK) || (j == GATES);
      end
    end
    if (r >= NR - 2) gm = 0;
    return {gm, gs, gc, ss, le, oe};
  endfunction

  function automatic bit exp_ready(int p);
    int r = p / RL;
    int c = p % RL;
    return (r >= 6) && (r - 6 < GATES) && c >= LEAD && c < LEAD + DCLK;
  endfunction

  function automatic string tag_for(int fld, int p);
    int r = p / RL;
    int c = p % RL;
    if (fld == 5 || r >= NR - 2) return "R3";
    if (r < 3) return "R4";
    if (r < 6) return "R5";
    if (fld == 4 || fld == 3) return "R7";
    if (r - 6 == GATES && c >= LEAD) return "R9";
    return (c < LEAD) ? "R6" : "R8";
  endfunction

  task automatic chk_pins(input logic [5:0] exp, input int p, input bit idle);
    logic [5:0] got = {gate_mode_o, gate_start_o, gate_clk_o, src_start_o, src_latch_o, src_oe_o};
    string names [6] = '{"oe", "latch", "src_start", "gate_clk", "gate_start", "gate_mode"};
    for (int f = 0; f < 6; f++)
      chk(idle ? "R1" : tag_for(f, p), names[f], int'(got[f]), int'(exp[f]));
  endtask

  task automatic run_frame(input int pct, input bit restart);
    int exp_data = 0;
    bit exp_under = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    @(posedge clk_i);
    for (int k = 0; k <= FRAME + 2; k++) begin
      @(negedge clk_i);
      start_i = restart && (k == FRAME / 2);
      if (k >= 1 && k <= FRAME) chk_pins(exp_pins(k - 1), k - 1, 1'b0);
      else begin
        chk_pins(6'b010100, 0, 1'b1);
        chk("R1", "data idle", int'(src_data_o), 0);
      end
      chk(restart ? "R11" : "R2", "busy", int'(busy_o), int'(k < FRAME));
      chk("R2", "done", int'(done_o), int'(k == FRAME + 1));
      chk("R10", "ready", int'(pix_ready_o), int'(k < FRAME && exp_ready(k)));
      chk("R10", "data", int'(src_data_o), exp_data);
      chk("R10", "underrun", int'(underrun_o), int'(exp_under));
      pix_valid_i = ($urandom % 100) < pct;
      pix_data_i  = 8'($urandom);
      exp_data = (pix_ready_o && pix_valid_i) ? int'(pix_data_i) : 0;
      if (pix_ready_o && !pix_valid_i) exp_under = 1'b1;
      @(posedge clk_i);
    end
    @(negedge clk_i);
    start_i = 1'b0;
    pix_valid_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk_pins(6'b010100, 0, 1'b1);
    chk("R1", "data", int'(src_data_o), 0);
    chk("R1", "ready", int'(pix_ready_o), 0);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "busy", int'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_pins(6'b010100, 0, 1'b1);
    run_frame(100, 1'b0);
    chk("R10", "no underrun on full feed", int'(underrun_o), 0);
    run_frame(70, 1'b1);
    chk("R10", "underrun sticky", int'(underrun_o), 1);
    run_frame(100, 1'b0);
    chk("R10", "underrun cleared", int'(underrun_o), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL R2 watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule